// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Unit

This block is the purely combinational rounding step that sits between an unpacked floating-point datapath and the logic that packs the result. It takes a mantissa carrying two extra low-order bits (guard, then round), a separate sticky bit that summarises everything shifted out below those, the sign of the value and a rounding-direction code. It drops the two extra bits, decides from them and from the mode whether one unit in the last place must be added, adds it with a carry that ripples across the whole mantissa, and reports both the increment and whether any precision was lost.

The block does not touch the exponent. When the increment overflows an all-ones mantissa, the result wraps to zero and a separate carry output goes high; the consumer uses it to bump the exponent or to detect that the value reached the next binade. The mantissa width and the width of the internal carry segments are parameters.

Top module: `fprnd_unit`

## Requirements
- R1: With no increment, `mant_out` equals `mant_in` shifted right by two (bit 1 is guard, bit 0 is round, both dropped) and `carry_out` is 0.
- R2: When guard, round and sticky are all 0, the result is exact: `rounded_up` is 0 and `inexact` is 0 in every mode.
- R3: `inexact` is 1 whenever guard, round or sticky is 1, regardless of `mode_in` and `sign_in`.
- R4: With `mode_in` = 2'b00 (nearest, ties to even), the increment happens only if guard is 1 and at least one of round, sticky, or the lowest kept bit (`mant_in[2]`) is 1.
- R5: With `mode_in` = 2'b01 (toward zero), no increment ever happens.
- R6: With `mode_in` = 2'b10 (toward plus infinity), the increment happens exactly when the result is inexact and `sign_in` is 0.
- R7: With `mode_in` = 2'b11 (toward minus infinity), the increment happens exactly when the result is inexact and `sign_in` is 1.
- R8: The increment adds one at bit 0 of the kept mantissa and carries across every internal segment; an all-ones kept mantissa becomes zero with `carry_out` = 1.
- R9: `rounded_up` is 1 exactly when the increment was applied, so that {`carry_out`, `mant_out`} equals the truncated mantissa plus `rounded_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_in | input | MANT_W+2 | Mantissa with guard at bit 1 and round at bit 0 |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 for negative |
| mode_in | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_out | output | MANT_W | Rounded mantissa with guard and round removed |
| carry_out | output | 1 | Increment overflowed the full mantissa width |
| rounded_up | output | 1 | One was added at the last kept place |
| inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The hardest case to reach is a carry that crosses every segment boundary: it needs the kept mantissa to be all ones (or all ones up to a given segment) at the same time as a rounding decision that increments, which random values almost never produce. The stimulus therefore overrides random mantissas with directed ones whose low bits are forced to ones up to each segment edge and to the full width, combined with guard and sticky patterns that force an increment in each mode. Exact ties under nearest-even, with the lowest kept bit both even and odd, are also set up directly rather than left to chance.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POSINF  = 2'b10,
    RND_NEGINF  = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/fprnd_decide.sv
module fprnd_decide
  import fprnd_pkg::*;
(
  input  logic      guard_i,
  input  logic      round_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      inc_o,
  output logic      lost_o
);

  logic lost;

  always_comb begin
    lost = guard_i | round_i | sticky_i;
    unique case (mode_i)
      RND_NEAREST: inc_o = guard_i & (round_i | sticky_i | lsb_i);
      RND_ZERO:    inc_o = 1'b0;
      RND_POSINF:  inc_o = lost & ~sign_i;
      RND_NEGINF:  inc_o = lost & sign_i;
      default:     inc_o = 1'b0;
    endcase
    lost_o = lost;
  end

  always_comb begin
    if (!$isunknown({guard_i, round_i, sticky_i, lsb_i, sign_i, mode_i})) begin
      // R2
      exact_noinc_chk: assert (guard_i | round_i | sticky_i | !inc_o);
      // R5
      trunc_noinc_chk: assert (mode_i != RND_ZERO || !inc_o);
      // R6
      posinf_sign_chk: assert (mode_i != RND_POSINF || !sign_i || !inc_o);
      // R7
      neginf_sign_chk: assert (mode_i != RND_NEGINF || sign_i || !inc_o);
    end
  end

endmodule

// File: rtl/fprnd_incr.sv
module fprnd_incr #(
  parameter int MANT_W = 64,
  parameter int SEG_W  = 16
) (
  input  logic [MANT_W-1:0] val_i,
  input  logic              inc_i,
  output logic [MANT_W-1:0] sum_o,
  output logic              cout_o
);

  localparam int NSEG  = (MANT_W + SEG_W - 1) / SEG_W;
  localparam int PAD_W = NSEG * SEG_W;
  localparam int EXT_W = PAD_W + 1;

  logic [PAD_W-1:0] val_pad;
  logic [EXT_W-1:0] sum_ext;
  logic [NSEG:0]    cy;

  assign val_pad = {{(PAD_W-MANT_W){1'b0}}, val_i};
  assign cy[0]   = inc_i;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg;
    assign seg = val_pad[s*SEG_W +: SEG_W];
    assign sum_ext[s*SEG_W +: SEG_W] = seg + {{(SEG_W-1){1'b0}}, cy[s]};
    assign cy[s+1] = cy[s] & (&seg);
  end

  assign sum_ext[EXT_W-1] = cy[NSEG];
  assign sum_o  = sum_ext[MANT_W-1:0];
  assign cout_o = sum_ext[MANT_W];

endmodule

// File: rtl/fprnd_unit.sv
module fprnd_unit
  import fprnd_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int SEG_W  = 16
) (
  input  logic [MANT_W+1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic [MANT_W-1:0] mant_out,
  output logic              carry_out,
  output logic              rounded_up,
  output logic              inexact
);

  logic [MANT_W-1:0] kept;
  logic              do_inc;
  rnd_mode_e         mode;

  assign kept = mant_in[MANT_W+1:2];
  assign mode = rnd_mode_e'(mode_in);

  fprnd_decide u_decide (
    .guard_i  (mant_in[1]),
    .round_i  (mant_in[0]),
    .sticky_i (sticky_in),
    .lsb_i    (mant_in[2]),
    .sign_i   (sign_in),
    .mode_i   (mode),
    .inc_o    (do_inc),
    .lost_o   (inexact)
  );

  fprnd_incr #(
    .MANT_W (MANT_W),
    .SEG_W  (SEG_W)
  ) u_incr (
    .val_i  (kept),
    .inc_i  (do_inc),
    .sum_o  (mant_out),
    .cout_o (carry_out)
  );

  assign rounded_up = do_inc;

  always_comb begin
    if (!$isunknown({mant_in, sticky_in, sign_in, mode_in})) begin
      // R9
      sum_match_chk: assert ({carry_out, mant_out} == {1'b0, kept} + {{MANT_W{1'b0}}, rounded_up});
      // R3
      lost_flag_chk: assert (!(mant_in[1] | mant_in[0] | sticky_in) || inexact);
    end
  end

endmodule

// File: tb/fprnd_unit_tb.sv
module fprnd_unit_tb_top;

  localparam int MW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [MW+1:0] mant_in;
  logic          sticky_in, sign_in;
  logic [1:0]    mode_in;
  logic [MW-1:0] mant_out;
  logic          carry_out, rounded_up, inexact;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  fprnd_unit #(.MANT_W(MW), .SEG_W(16)) dut_i (
    .mant_in    (mant_in),
    .sticky_in  (sticky_in),
    .sign_in    (sign_in),
    .mode_in    (mode_in),
    .mant_out   (mant_out),
    .carry_out  (carry_out),
    .rounded_up (rounded_up),
    .inexact    (inexact)
  );

  function automatic logic exp_inc(logic [MW+1:0] m, logic s, logic sg, logic [1:0] md);
    logic lost;
    lost = m[1] | m[0] | s;
    case (md)
      2'b00:   return m[1] & (m[0] | s | m[2]);
      2'b01:   return 1'b0;
      2'b10:   return lost & ~sg;
      default: return lost & sg;
    endcase
  endfunction

  task automatic apply(input logic [MW+1:0] m, input logic s, input logic sg,
                       input logic [1:0] md, input string tag);
    logic          e_inc, e_inx;
    logic [MW:0]   e_sum;
    @(negedge clk);
    mant_in = m; sticky_in = s; sign_in = sg; mode_in = md;
    #1;
    e_inc = exp_inc(m, s, sg, md);
    e_inx = m[1] | m[0] | s;
    e_sum = {1'b0, m[MW+1:2]} + {{MW{1'b0}}, e_inc};
    n_chk++;
    if ({carry_out, mant_out} !== e_sum || rounded_up !== e_inc || inexact !== e_inx) begin
      n_fail++;
      $display("FAIL %s: got c=%b m=%h up=%b nx=%b exp c=%b m=%h up=%b nx=%b",
               tag, carry_out, mant_out, rounded_up, inexact,
               e_sum[MW], e_sum[MW-1:0], e_inc, e_inx);
    end
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd2024));
        // R1 R2: all-zero input
        apply('0, 1'b0, 1'b0, 2'b00, "R1 R2 zero");
        for (int md = 0; md < 4; md++) begin
          apply({64'h5, 2'b00}, 1'b0, 1'b1, md[1:0], "R2 exact");
          apply({64'h5, 2'b00}, 1'b0, 1'b0, md[1:0], "R2 exact");
          apply({64'h8, 2'b00}, 1'b1, 1'b0, md[1:0], "R3 sticky only");
        end
        // R4 ties and near-ties
        apply({64'h4, 2'b10}, 1'b0, 1'b0, 2'b00, "R4 tie even");
        apply({64'h5, 2'b10}, 1'b0, 1'b0, 2'b00, "R4 tie odd");
        apply({64'h4, 2'b11}, 1'b0, 1'b0, 2'b00, "R4 above half");
        apply({64'h4, 2'b10}, 1'b1, 1'b0, 2'b00, "R4 sticky above half");
        apply({64'h5, 2'b01}, 1'b1, 1'b0, 2'b00, "R4 below half");
        // R5
        apply({64'h7, 2'b11}, 1'b1, 1'b0, 2'b01, "R5 trunc pos");
        apply({64'h7, 2'b11}, 1'b1, 1'b1, 2'b01, "R5 trunc neg");
        // R6 R7
        apply({64'h9, 2'b01}, 1'b0, 1'b0, 2'b10, "R6 pos");
        apply({64'h9, 2'b01}, 1'b0, 1'b1, 2'b10, "R6 neg");
        apply({64'h9, 2'b00}, 1'b1, 1'b1, 2'b11, "R7 neg");
        apply({64'h9, 2'b00}, 1'b1, 1'b0, 2'b11, "R7 pos");
        // R8 carries across each segment edge and the full width
        for (int k = 1; k <= 4; k++) begin
          logic [63:0] ones;
          ones = (k == 4) ? '1 : ((64'h1 << (16*k)) - 64'h1);
          apply({ones, 2'b11}, 1'b0, 1'b0, 2'b00, "R8 ripple");
          apply({ones, 2'b00}, 1'b1, 1'b1, 2'b11, "R8 ripple");
        end
        // R1 R3 R4 R6 R7 R9 random
        for (int i = 0; i < 4000; i++) begin
          logic [MW+1:0] m;
          m = {$urandom(), $urandom(), 2'($urandom())};
          if ((i % 9) == 0) m[MW+1:2] = '1;
          apply(m, 1'($urandom()), 1'($urandom()), 2'(i % 4), "R1 R3 R4 R6 R7 R9 random");
        end
      end
      begin
        while (cyc < 100000) begin
          @(posedge clk);
          cyc++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule